// File: doc/BRIEF.md
# External Memory Bus Cycle Sequencer

This block drives the external memory bus of an 8-bit controller core that executes code from off-chip program memory. Each machine cycle it shapes the address latch strobe, the program-store read strobe, the data read and write strobes, a shared low address/data byte lane with its own output enable, and a high address byte. The core hands over one request per machine cycle: an internal fetch, an external fetch, a data read or a data write. A data access is issued as a fetch cycle followed by a data cycle.

The machine cycle is 12 oscillator clocks, or 6 in the doubled-speed mode. Internally the cycle is a 12-step phase count. The fast mode advances it two steps per clock, so a single strobe schedule serves both modes. The sequencer raises `mcEnd` on the last clock of every cycle. All request inputs, and the mode select, are taken at that clock edge and at no other.

Top module: `busseq_top`

## Requirements
- R1: A machine cycle lasts 12 clocks when `x2Mode` was low at the cycle's start and 6 clocks when it was high. `mcEnd` is high on exactly the last clock of each cycle.
- R2: In fetch cycles `ale` pulses twice per cycle, once in each half. In normal mode it is high on the first two clocks of each 6-clock half. In fast mode it is high on the first clock of each 3-clock half.
- R3: In read and write cycles `ale` pulses only in the first half. The second-half pulse is left out.
- R4: `psenN` is low only in external fetch cycles: on clocks 3 to 5 of each half in normal mode, and on the last clock of each half in fast mode. It stays high in internal fetch, read and write cycles.
- R5: In a read cycle `rdN`, and in a write cycle `wrN`, is low from clock 3 (normal) or clock 2 (fast) through the end of the cycle. Otherwise both stay high.
- R6: The low address byte is driven (`adOe` high) on clocks 0 to 2 of a half in normal mode and on clocks 0 to 1 in fast mode. This happens in both halves of an external fetch cycle and in the first half of a data cycle. Fetch cycles drive `reqPc[7:0]` and data cycles drive `reqAddr[7:0]`. Internal fetch cycles never drive the lane.
- R7: A write cycle drives `wrData` on the lane for as long as `wrN` is low. A read cycle releases the lane outside its address window.
- R8: `addrHi` shows the upper byte of `reqPc` in fetch cycles and the upper byte of `reqAddr` in data cycles with `reqWide`=1. In data cycles with `reqWide`=0 it shows `p2Reg`. It holds one value for the whole cycle.
- R9: In a read cycle `busIn` is captured on the last clock into `rdData`, and `rdValid` is high for the one clock after.
- R10: `reqOp` encodes 0 internal fetch, 1 external fetch, 2 data read and 3 data write. Request inputs and `x2Mode` are sampled only at the edge that ends a cycle (`mcEnd` high); changes at other times have no effect on the outputs.
- R11: `rst` is synchronous and active high. While it is high, all strobes are inactive, the lane is released, and `addrHi`, `mcEnd` and `rdValid` are 0. The first cycle after reset is a normal-mode internal fetch at address 0.
- R12: A change of `x2Mode` takes effect at the next cycle boundary, including in the middle of a fetch and data cycle pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous reset, active high |
| x2Mode | input | 1 | 1 selects 6-clock machine cycles |
| reqOp | input | 2 | Next-cycle operation |
| reqPc | input | 16 | Fetch address |
| reqAddr | input | 16 | Data address |
| reqWide | input | 1 | 1 selects 16-bit data addressing |
| p2Reg | input | 8 | High byte for 8-bit data addressing |
| wrData | input | 8 | Write data |
| busIn | input | 8 | Lane read value |
| mcEnd | output | 1 | Last clock of the machine cycle |
| ale | output | 1 | Address latch strobe, active high |
| psenN | output | 1 | Program read strobe, active low |
| rdN | output | 1 | Data read strobe, active low |
| wrN | output | 1 | Data write strobe, active low |
| adOut | output | 8 | Lane drive value |
| adOe | output | 1 | Lane output enable |
| addrHi | output | 8 | High address byte |
| rdData | output | 8 | Captured read data |
| rdValid | output | 1 | Read data valid pulse |

## Verification
The hardest case to reach from the ports is a data cycle that runs in a different clock mode from the fetch cycle before it. In that case the strobe window, the single ALE pulse and the read capture point all move at once. To reach it, the stimulus toggles `x2Mode` at random on every clock and weights the operations toward reads and writes, so mode changes land on fetch-to-data boundaries many times. Because every request input is also changed on every clock, the same run shows that values between boundaries are ignored.

// File: rtl/busseq_pkg.sv
package busseq_pkg;

  localparam int PHASE_CNT = 12;
  localparam int HALF_CNT  = PHASE_CNT / 2;
  localparam int PH_W      = $clog2(PHASE_CNT);

  typedef enum logic [1:0] {
    OP_FETCH_INT = 2'd0,
    OP_FETCH_EXT = 2'd1,
    OP_READ      = 2'd2,
    OP_WRITE     = 2'd3
  } busOp_e;

  typedef struct packed {
    logic load;      // last clock of cycle: latch next request
    logic useData;   // current cycle is a data cycle
    logic drvAddr;   // lane carries low address
    logic drvData;   // lane carries write data
    logic capture;   // sample lane into read register
    logic ale;
    logic psen;
    logic rdStb;
    logic wrStb;
  } seqStrobe_t;

endpackage

// File: rtl/busseq_ctrl.sv
module busseq_ctrl
  import busseq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  busOp_e     reqOp,
  input  logic       x2Req,
  output seqStrobe_t stb
);

  localparam logic [PH_W-1:0] LAST_NORM = PH_W'(PHASE_CNT - 1);
  localparam logic [PH_W-1:0] LAST_FAST = PH_W'(PHASE_CNT - 2);
  localparam logic [PH_W-1:0] HALF_PH   = PH_W'(HALF_CNT);
  localparam logic [PH_W-1:0] ADDR_END  = PH_W'(HALF_CNT / 2);  // exclusive
  localparam logic [PH_W-1:0] ALE_END   = PH_W'(HALF_CNT / 3);  // exclusive

  logic [PH_W-1:0] phase;
  logic [PH_W-1:0] subPhase;
  logic [PH_W-1:0] lastPh;
  logic            x2Cur;
  logic            secondHalf;
  logic            atEnd;
  logic            isData;
  busOp_e          curOp;

  assign lastPh     = x2Cur ? LAST_FAST : LAST_NORM;
  assign atEnd      = (phase == lastPh);
  assign secondHalf = (phase >= HALF_PH);
  assign subPhase   = secondHalf ? (phase - HALF_PH) : phase;
  assign isData     = (curOp == OP_READ) || (curOp == OP_WRITE);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= '0;
      curOp <= OP_FETCH_INT;
      x2Cur <= 1'b0;
    end else if (atEnd) begin
      phase <= '0;
      curOp <= reqOp;
      x2Cur <= x2Req;
    end else begin
      phase <= phase + (x2Cur ? PH_W'(2) : PH_W'(1));
    end
  end

  always_comb begin
    stb         = '0;
    stb.load    = atEnd;
    stb.useData = isData;
    stb.ale     = (subPhase < ALE_END) && !(isData && secondHalf);
    stb.psen    = (curOp == OP_FETCH_EXT) && (subPhase >= ADDR_END);
    stb.rdStb   = (curOp == OP_READ)  && (phase >= ADDR_END);
    stb.wrStb   = (curOp == OP_WRITE) && (phase >= ADDR_END);
    stb.drvAddr = (subPhase < ADDR_END) &&
                  ((curOp == OP_FETCH_EXT) || (isData && !secondHalf));
    stb.drvData = (curOp == OP_WRITE) && (phase >= ADDR_END);
    stb.capture = (curOp == OP_READ) && atEnd;
  end

endmodule

// File: rtl/busseq_dpath.sv
module busseq_dpath
  import busseq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  seqStrobe_t           stb,
  input  logic [ADDR_W-1:0]    reqPc,
  input  logic [ADDR_W-1:0]    reqAddr,
  input  logic                 reqWide,
  input  logic [ADDR_W-DATA_W-1:0] p2Reg,
  input  logic [DATA_W-1:0]    wrData,
  input  logic [DATA_W-1:0]    busIn,
  output logic [DATA_W-1:0]    adOut,
  output logic [ADDR_W-DATA_W-1:0] addrHi,
  output logic [DATA_W-1:0]    rdData,
  output logic                 rdValid
);

  localparam int HI_W = ADDR_W - DATA_W;

  logic [ADDR_W-1:0] pcQ;
  logic [ADDR_W-1:0] dataAddrQ;
  logic              wideQ;
  logic [HI_W-1:0]   p2Q;
  logic [DATA_W-1:0] wrQ;
  logic [DATA_W-1:0] lowByte;

  always_ff @(posedge clk) begin
    if (rst) begin
      pcQ       <= '0;
      dataAddrQ <= '0;
      wideQ     <= 1'b0;
      p2Q       <= '0;
      wrQ       <= '0;
    end else if (stb.load) begin
      pcQ       <= reqPc;
      dataAddrQ <= reqAddr;
      wideQ     <= reqWide;
      p2Q       <= p2Reg;
      wrQ       <= wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      rdValid <= stb.capture;
      if (stb.capture) rdData <= busIn;
    end
  end

  assign lowByte = stb.useData ? dataAddrQ[DATA_W-1:0] : pcQ[DATA_W-1:0];
  assign adOut   = stb.drvData ? wrQ : lowByte;

  always_comb begin
    if (!stb.useData)  addrHi = pcQ[ADDR_W-1:DATA_W];
    else if (wideQ)    addrHi = dataAddrQ[ADDR_W-1:DATA_W];
    else               addrHi = p2Q;
  end

endmodule

// File: rtl/busseq_top.sv
module busseq_top
  import busseq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     x2Mode,
  input  logic [1:0]               reqOp,
  input  logic [ADDR_W-1:0]        reqPc,
  input  logic [ADDR_W-1:0]        reqAddr,
  input  logic                     reqWide,
  input  logic [ADDR_W-DATA_W-1:0] p2Reg,
  input  logic [DATA_W-1:0]        wrData,
  input  logic [DATA_W-1:0]        busIn,
  output logic                     mcEnd,
  output logic                     ale,
  output logic                     psenN,
  output logic                     rdN,
  output logic                     wrN,
  output logic [DATA_W-1:0]        adOut,
  output logic                     adOe,
  output logic [ADDR_W-DATA_W-1:0] addrHi,
  output logic [DATA_W-1:0]        rdData,
  output logic                     rdValid
);

  localparam int HI_W = ADDR_W - DATA_W;

  seqStrobe_t        stb;
  logic [DATA_W-1:0] adRaw;
  logic [HI_W-1:0]   hiRaw;

  busseq_ctrl u_ctrl (
    .clk   (clk),
    .rst   (rst),
    .reqOp (busOp_e'(reqOp)),
    .x2Req (x2Mode),
    .stb   (stb)
  );

  busseq_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dpath (
    .clk     (clk),
    .rst     (rst),
    .stb     (stb),
    .reqPc   (reqPc),
    .reqAddr (reqAddr),
    .reqWide (reqWide),
    .p2Reg   (p2Reg),
    .wrData  (wrData),
    .busIn   (busIn),
    .adOut   (adRaw),
    .addrHi  (hiRaw),
    .rdData  (rdData),
    .rdValid (rdValid)
  );

  assign mcEnd  = !rst && stb.load;
  assign ale    = !rst && stb.ale;
  assign psenN  = rst || !stb.psen;
  assign rdN    = rst || !stb.rdStb;
  assign wrN    = rst || !stb.wrStb;
  assign adOe   = !rst && (stb.drvAddr || stb.drvData);
  assign adOut  = rst ? '0 : adRaw;
  assign addrHi = rst ? '0 : hiRaw;

endmodule

// File: rtl/busseq_chk.sv
module busseq_chk #(
  parameter int HI_W = 8
) (
  input logic            clk,
  input logic            rst,
  input logic            mcEnd,
  input logic            ale,
  input logic            psenN,
  input logic            rdN,
  input logic            wrN,
  input logic            adOe,
  input logic [HI_W-1:0] addrHi,
  input logic            rdValid
);

  AST_CYCLE_STARTS_WITH_ALE: assert property (@(posedge clk) disable iff (rst)
    mcEnd |=> ale); // R2

  AST_NO_ALE_DURING_STROBE: assert property (@(posedge clk) disable iff (rst)
    (!rdN || !wrN) |-> !ale); // R3

  AST_ONE_STROBE_AT_A_TIME: assert property (@(posedge clk) disable iff (rst)
    $onehot0({!psenN, !rdN, !wrN})); // R5

  AST_WRITE_DRIVES_LANE: assert property (@(posedge clk) disable iff (rst)
    !wrN |-> adOe); // R7

  AST_HIGH_BYTE_HELD: assert property (@(posedge clk) disable iff (rst)
    !$past(mcEnd) |-> $stable(addrHi)); // R8

  AST_READ_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
    rdValid |=> !rdValid); // R9

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |-> (!ale && psenN && rdN && wrN && !adOe && !mcEnd)); // R11

endmodule

bind busseq_top busseq_chk #(.HI_W(HI_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .mcEnd   (mcEnd),
  .ale     (ale),
  .psenN   (psenN),
  .rdN     (rdN),
  .wrN     (wrN),
  .adOe    (adOe),
  .addrHi  (addrHi),
  .rdValid (rdValid)
);

// File: tb/busseq_top_bench.sv
module busseq_top_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        x2Mode = 1'b0;
  logic [1:0]  reqOp = 2'd0;
  logic [15:0] reqPc = 16'h0;
  logic [15:0] reqAddr = 16'h0;
  logic        reqWide = 1'b0;
  logic [7:0]  p2Reg = 8'h0;
  logic [7:0]  wrData = 8'h0;
  logic [7:0]  busIn = 8'h0;
  logic        mcEnd, ale, psenN, rdN, wrN, adOe, rdValid;
  logic [7:0]  adOut, addrHi, rdData;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  busseq_top u_busseq_top (
    .clk(clk), .rst(rst), .x2Mode(x2Mode), .reqOp(reqOp), .reqPc(reqPc),
    .reqAddr(reqAddr), .reqWide(reqWide), .p2Reg(p2Reg), .wrData(wrData),
    .busIn(busIn), .mcEnd(mcEnd), .ale(ale), .psenN(psenN), .rdN(rdN),
    .wrN(wrN), .adOut(adOut), .adOe(adOe), .addrHi(addrHi),
    .rdData(rdData), .rdValid(rdValid)
  );

  // Reference model: clock index inside the machine cycle plus the request
  // captured at the previous boundary.
  int          mk = 0;
  int          mOp = 0;
  bit          mX2 = 1'b0;
  logic [15:0] mPc = 16'h0;
  logic [15:0] mAddr = 16'h0;
  bit          mWide = 1'b0;
  logic [7:0]  mP2 = 8'h0;
  logic [7:0]  mWr = 8'h0;
  logic [7:0]  mRd = 8'h0;
  bit          mValid = 1'b0;

  function automatic int cycLen(bit fast);
    return fast ? 6 : 12;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      mk <= 0; mOp <= 0; mX2 <= 1'b0; mPc <= '0; mAddr <= '0;
      mWide <= 1'b0; mP2 <= '0; mWr <= '0; mRd <= '0; mValid <= 1'b0;
    end else begin
      mValid <= (mOp == 2) && (mk == cycLen(mX2) - 1);
      if ((mOp == 2) && (mk == cycLen(mX2) - 1)) mRd <= busIn;
      if (mk == cycLen(mX2) - 1) begin
        mk <= 0; mOp <= int'(reqOp); mX2 <= x2Mode; mPc <= reqPc;
        mAddr <= reqAddr; mWide <= reqWide; mP2 <= p2Reg; mWr <= wrData;
      end else begin
        mk <= mk + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s at %0t: actual=%0h expected=%0h", tag, $time, act, exp);
    end
  endtask

  task automatic compareAll();
    int  h, j, sFrom;
    bit  sec, isData, ext, eAle, ePsen, eRd, eWr, drvA, drvD, eOe, eEnd;
    logic [7:0] eAd, eHi;
    if (rst) begin
      chk(!ale && psenN && rdN && wrN, "R11 strobes in reset",
          int'({ale, psenN, rdN, wrN}), 4'b0111);
      chk(!adOe && addrHi == 8'h0 && !mcEnd, "R11 lane/high byte in reset",
          int'({adOe, addrHi, mcEnd}), 0);
      return;
    end
    h = cycLen(mX2) / 2;
    j = mk % h;
    sec = (mk >= h);
    isData = (mOp >= 2);
    ext = (mOp == 1);
    sFrom = mX2 ? 2 : 3;
    eAle = (mX2 ? (j == 0) : (j < 2)) && !(isData && sec);
    ePsen = ext && (mX2 ? (j == 2) : (j >= 3));
    eRd = (mOp == 2) && (mk >= sFrom);
    eWr = (mOp == 3) && (mk >= sFrom);
    drvA = (mX2 ? (j < 2) : (j < 3)) && (ext || (isData && !sec));
    drvD = eWr;
    eOe = drvA || drvD;
    eEnd = (mk == cycLen(mX2) - 1);
    eAd = drvD ? mWr : (isData ? mAddr[7:0] : mPc[7:0]);
    eHi = !isData ? mPc[15:8] : (mWide ? mAddr[15:8] : mP2);
    chk(mcEnd == eEnd, "R1 cycle end", mcEnd, eEnd);
    chk(ale == eAle, (isData ? "R3 ale in data cycle" : "R2 ale in fetch cycle"), ale, eAle);
    chk(psenN == !ePsen, "R4 psen", psenN, !ePsen);
    chk(rdN == !eRd && wrN == !eWr, "R5 rd/wr strobes", int'({rdN, wrN}), int'({!eRd, !eWr}));
    chk(adOe == eOe, (drvD ? "R7 write lane enable" : "R6 address lane enable"), adOe, eOe);
    if (eOe) chk(adOut == eAd, (drvD ? "R7 write data" : "R6 low address"), adOut, eAd);
    chk(addrHi == eHi, "R8 high byte", addrHi, eHi);
    chk(rdValid == mValid, "R9 read valid", rdValid, mValid);
    if (mValid) chk(rdData == mRd, "R9 read data", rdData, mRd);
  endtask

  // New random request values on every clock: R10 ignore-between-boundaries.
  task automatic driveRandom(input int x2Pct, input bit dataHeavy);
    int r;
    r = int'($urandom_range(0, 99));
    if (dataHeavy) reqOp = (r < 20) ? 2'd1 : (r < 30) ? 2'd0 : (r < 65) ? 2'd2 : 2'd3;
    else           reqOp = 2'($urandom_range(0, 3));
    x2Mode  = (int'($urandom_range(0, 99)) < x2Pct);
    reqPc   = 16'($urandom);
    reqAddr = 16'($urandom);
    reqWide = 1'($urandom);
    p2Reg   = 8'($urandom);
    wrData  = 8'($urandom);
    busIn   = 8'($urandom);
  endtask

  task automatic runPhase(input int n, input int x2Pct, input bit dataHeavy);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compareAll();
      driveRandom(x2Pct, dataHeavy);
    end
  endtask

  initial begin
    // R11: reset state, then the first cycle must be a normal internal fetch
    repeat (3) begin @(negedge clk); compareAll(); end
    rst = 1'b0;
    runPhase(14, 0, 1'b0);      // R11 first cycle after reset
    runPhase(600, 0, 1'b0);     // R1..R10 normal mode
    runPhase(600, 100, 1'b1);   // fast mode, data heavy
    runPhase(1500, 50, 1'b1);   // R12 mode flips at fetch/data boundaries
    @(negedge clk); rst = 1'b1; // R11 reset in mid-cycle
    repeat (2) begin @(negedge clk); compareAll(); end
    rst = 1'b0;
    runPhase(400, 30, 1'b1);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired: actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule